// File: doc/BRIEF.md
# Clock-Synchronous Serial Shift Port

This block moves one word at a time over a three-wire synchronous link: a transfer clock, a serial data output and a serial data input. A single transfer clock drives both the shift-out path and the shift-in path, so every word sent is matched by a word received. The clock comes from one of two places. It can be made on chip by a prescaler followed by a reload divider, and it then also appears on `sclk_out`. It can also be supplied on `sclk_in`, in which case it is passed through a synchroniser and only its edges are used.

The word length can be changed at run time to any value from 8 to 16 bits. The bit order can be least significant first or most significant first. The clock polarity bit chooses which edge launches data and which edge samples it. A holding register takes the next word to send. A one-cycle transmit DMA request fires when that word moves into the shifter, and a one-cycle receive DMA request fires when a received word is ready. The only error reported is receive overrun.

Top module: `ssi_port`

## Requirements
- R1: The word length is `cfg_len`. A value below 8 is treated as 8 and a value above 16 as 16. A received word appears on `rx_data` right-aligned, and the bits above the length read zero.
- R2: When `cfg_msb_first` is 0, bit 0 of the word is sent and received first. When it is 1, bit length-1 goes first and bit 0 goes last.
- R3: When `cfg_clk_pol` is 0, the transfer clock idles high. `sdo` changes only after a falling edge, and `sdi` is sampled on the rising edge. When `cfg_clk_pol` is 1, all of this is inverted. A word takes one launch edge and one capture edge per bit, and the launch edge comes first.
- R4: With the internal clock (`cfg_ext_clk`=0), `sclk_out` toggles every (`cfg_reload`+1)·D system cycles during a transfer. D is 1, 8, 32 or 256 for `cfg_presc` values 0, 1, 2 and 3. The product must be at least 2. Between words, `sclk_out` rests at the idle level.
- R5: With the external clock (`cfg_ext_clk`=1), `sclk_in` is synchronised before use and must run no faster than one sixteenth of `clk`. Edges that arrive while no word is in flight have no effect.
- R6: `tx_load` writes `tx_data` into the holding register only when that register is empty. `tx_dreq` pulses for one cycle when the held word enters the shifter, and the held word then starts transferring.
- R7: `rx_dreq` pulses for one cycle on the cycle that `rx_data` takes a completed word. `rx_read` marks the word as taken.
- R8: `rx_ovr` is set when a word completes while the previous word is untaken and `rx_read` is low in that cycle. The new word still replaces `rx_data`. `rx_ovr` stays set until `ovr_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_clk | input | 1 | 1 selects the external transfer clock |
| cfg_clk_pol | input | 1 | Clock polarity; 0 means idle high and launch on the falling edge |
| cfg_msb_first | input | 1 | 1 sends the most significant bit first |
| cfg_len | input | 5 | Word length, clamped to the range 8..16 |
| cfg_presc | input | 2 | Prescaler select: /1, /8, /32, /256 |
| cfg_reload | input | 8 | Reload value of the divider |
| tx_data | input | 16 | Word to send |
| tx_load | input | 1 | Strobe that writes the holding register |
| rx_read | input | 1 | Strobe that marks `rx_data` as taken |
| ovr_clr | input | 1 | Strobe that clears the overrun flag |
| sclk_in | input | 1 | External transfer clock |
| sdi | input | 1 | Serial data in |
| sclk_out | output | 1 | Internally generated transfer clock |
| sdo | output | 1 | Serial data out |
| rx_data | output | 16 | Last received word |
| tx_dreq | output | 1 | Transmit DMA request pulse |
| rx_dreq | output | 1 | Receive DMA request pulse |
| rx_ovr | output | 1 | Receive overrun flag |

## Verification
Internal-clock words are looped back from `sdo` to `sdi` using random lengths, orders, polarities and divider settings. Any loss, duplication or misplacement of a bit shows up as a mismatch in the echoed word, and two out-of-range lengths check the clamp. External-clock words are clocked by the bench, which checks every `sdo` bit against the chosen order and feeds back an unrelated word. This separates the transmit order from the receive order and confirms which edge launches and which samples. Divider settings with known toggle intervals, back-to-back words with no read in between, and clock edges while idle cover the timing, overrun and ignore cases.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

  localparam int unsigned SSI_MIN_LEN = 8;
  localparam int unsigned SSI_MAX_LEN = 16;
  localparam int unsigned SSI_PRE_W   = 8;

  typedef enum logic [1:0] {
    PRE_DIV1   = 2'd0,
    PRE_DIV8   = 2'd1,
    PRE_DIV32  = 2'd2,
    PRE_DIV256 = 2'd3
  } presc_e;

  // terminal count of the prescaler for each division ratio
  function automatic logic [SSI_PRE_W-1:0] presc_limit(input presc_e sel);
    logic [SSI_PRE_W-1:0] lim;
    case (sel)
      PRE_DIV1:   lim = SSI_PRE_W'(0);
      PRE_DIV8:   lim = SSI_PRE_W'(7);
      PRE_DIV32:  lim = SSI_PRE_W'(31);
      default:    lim = SSI_PRE_W'(255);
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/ssi_baud_gen.sv
module ssi_baud_gen
  import ssi_pkg::*;
#(
  parameter int unsigned RELOAD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                idle_lvl,
  input  logic [1:0]          presc_sel,
  input  logic [RELOAD_W-1:0] reload,
  output logic                sclk,
  output logic                tgl
);

  logic [SSI_PRE_W-1:0] pre_q, pre_n;
  logic [RELOAD_W-1:0]  div_q, div_n;
  logic                 sclk_q, sclk_n;
  logic                 tgl_q, tgl_n;
  logic [SSI_PRE_W-1:0] pre_lim;

  assign pre_lim = presc_limit(presc_e'(presc_sel));

  always_comb begin
    pre_n  = pre_q;
    div_n  = div_q;
    sclk_n = sclk_q;
    tgl_n  = 1'b0;
    if (!run) begin
      pre_n  = '0;
      div_n  = reload;
      sclk_n = idle_lvl;
    end else if (pre_q == pre_lim) begin
      pre_n = '0;
      if (div_q == '0) begin
        div_n  = reload;
        sclk_n = ~sclk_q;
        tgl_n  = 1'b1;
      end else begin
        div_n = div_q - RELOAD_W'(1);
      end
    end else begin
      pre_n = pre_q + SSI_PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      div_q  <= '0;
      sclk_q <= 1'b1;
      tgl_q  <= 1'b0;
    end else begin
      pre_q  <= pre_n;
      div_q  <= div_n;
      sclk_q <= sclk_n;
      tgl_q  <= tgl_n;
    end
  end

  assign sclk = sclk_q;
  assign tgl  = tgl_q;

  // R4: the divide product is at least 2, so two toggles are never adjacent
  p_toggle_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tgl |=> !tgl);

  // R4: a stopped generator makes no edges
  p_stopped_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tgl);

endmodule

// File: rtl/ssi_edge_sel.sv
module ssi_edge_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic use_ext,
  input  logic idle_lvl,
  input  logic sclk_ext,
  input  logic int_sclk,
  input  logic int_tgl,
  output logic launch_ev,
  output logic capture_ev
);

  localparam int unsigned SYNC_STAGES = 3;

  logic [SYNC_STAGES-1:0] sync_q, sync_n;
  logic                   ext_lvl, ext_prev, ext_chg;
  logic                   int_chg;

  always_comb begin
    sync_n = {sync_q[SYNC_STAGES-2:0], sclk_ext};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_n;
  end

  assign ext_lvl  = sync_q[SYNC_STAGES-2];
  assign ext_prev = sync_q[SYNC_STAGES-1];
  assign ext_chg  = ext_lvl ^ ext_prev;
  assign int_chg  = int_tgl;

  // leaving the idle level launches, returning to it captures
  always_comb begin
    if (use_ext) begin
      launch_ev  = ext_chg && (ext_lvl != idle_lvl);
      capture_ev = ext_chg && (ext_lvl == idle_lvl);
    end else begin
      launch_ev  = int_chg && (int_sclk != idle_lvl);
      capture_ev = int_chg && (int_sclk == idle_lvl);
    end
  end

  // R5: with the external clock selected, the internal generator is silent
  p_ext_gen_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    use_ext |-> !int_tgl);

endmodule

// File: rtl/ssi_shift_engine.sv
module ssi_shift_engine #(
  parameter int unsigned MAX_LEN = 16,
  parameter int unsigned LEN_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEN_W-1:0]   len_eff,
  input  logic               msb_first,
  input  logic [MAX_LEN-1:0] tx_data,
  input  logic               tx_load,
  input  logic               rx_read,
  input  logic               ovr_clr,
  input  logic               launch_ev,
  input  logic               capture_ev,
  input  logic               sdi,
  output logic               busy,
  output logic               sdo,
  output logic [MAX_LEN-1:0] rx_data,
  output logic               tx_dreq,
  output logic               rx_dreq,
  output logic               rx_ovr
);

  localparam int unsigned IDX_W = $clog2(MAX_LEN);

  logic               busy_q, busy_n;
  logic               phase_q, phase_n;
  logic [LEN_W-1:0]   cnt_q, cnt_n;
  logic [MAX_LEN-1:0] txsh_q, txsh_n;
  logic [MAX_LEN-1:0] rxsh_q, rxsh_n;
  logic [MAX_LEN-1:0] hold_q, hold_n;
  logic               hold_full_q, hold_full_n;
  logic [MAX_LEN-1:0] rxd_q, rxd_n;
  logic               rx_full_q, rx_full_n;
  logic               ovr_q, ovr_n;
  logic               sdo_q, sdo_n;
  logic               txr_q, txr_n;
  logic               rxr_q, rxr_n;

  logic [IDX_W-1:0]   last_idx;
  logic [IDX_W-1:0]   rx_pos;
  logic [MAX_LEN-1:0] rx_tmp;
  logic               last_bit;

  assign last_idx = IDX_W'(len_eff - LEN_W'(1));
  assign rx_pos   = msb_first ? (last_idx - cnt_q[IDX_W-1:0]) : cnt_q[IDX_W-1:0];
  assign last_bit = (cnt_q == (len_eff - LEN_W'(1)));

  always_comb begin
    rx_tmp         = rxsh_q;
    rx_tmp[rx_pos] = sdi;
  end

  always_comb begin
    busy_n      = busy_q;
    phase_n     = phase_q;
    cnt_n       = cnt_q;
    txsh_n      = txsh_q;
    rxsh_n      = rxsh_q;
    hold_n      = hold_q;
    hold_full_n = hold_full_q;
    rxd_n       = rxd_q;
    rx_full_n   = rx_full_q;
    ovr_n       = ovr_q;
    sdo_n       = sdo_q;
    txr_n       = 1'b0;
    rxr_n       = 1'b0;

    if (tx_load && !hold_full_q) begin
      hold_n      = tx_data;
      hold_full_n = 1'b1;
    end
    if (rx_read) rx_full_n = 1'b0;
    if (ovr_clr) ovr_n     = 1'b0;

    if (!busy_q) begin
      if (hold_full_q) begin
        busy_n      = 1'b1;
        phase_n     = 1'b0;
        cnt_n       = '0;
        txsh_n      = hold_q;
        rxsh_n      = '0;
        hold_full_n = 1'b0;
        txr_n       = 1'b1;
      end
    end else if (launch_ev && !phase_q) begin
      sdo_n   = msb_first ? txsh_q[last_idx] : txsh_q[0];
      txsh_n  = msb_first ? (txsh_q << 1) : (txsh_q >> 1);
      phase_n = 1'b1;
    end else if (capture_ev && phase_q) begin
      rxsh_n  = rx_tmp;
      phase_n = 1'b0;
      if (last_bit) begin
        busy_n    = 1'b0;
        rxd_n     = rx_tmp;
        rxr_n     = 1'b1;
        rx_full_n = 1'b1;
        if (rx_full_q && !rx_read) ovr_n = 1'b1;
      end else begin
        cnt_n = cnt_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      phase_q     <= 1'b0;
      cnt_q       <= '0;
      txsh_q      <= '0;
      rxsh_q      <= '0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      rxd_q       <= '0;
      rx_full_q   <= 1'b0;
      ovr_q       <= 1'b0;
      sdo_q       <= 1'b1;
      txr_q       <= 1'b0;
      rxr_q       <= 1'b0;
    end else begin
      busy_q      <= busy_n;
      phase_q     <= phase_n;
      cnt_q       <= cnt_n;
      txsh_q      <= txsh_n;
      rxsh_q      <= rxsh_n;
      hold_q      <= hold_n;
      hold_full_q <= hold_full_n;
      rxd_q       <= rxd_n;
      rx_full_q   <= rx_full_n;
      ovr_q       <= ovr_n;
      sdo_q       <= sdo_n;
      txr_q       <= txr_n;
      rxr_q       <= rxr_n;
    end
  end

  assign busy    = busy_q;
  assign sdo     = sdo_q;
  assign rx_data = rxd_q;
  assign tx_dreq = txr_q;
  assign rx_dreq = rxr_q;
  assign rx_ovr  = ovr_q;

  // R1: the bit counter never passes the programmed length
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < len_eff));

  // R3: the data line moves only after a launch edge of a live transfer
  p_sdo_on_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $past(launch_ev && busy_q));

  // R6: the transmit request is one cycle long and opens a transfer
  p_txreq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    txr_q |=> (!txr_q && busy_q));

  // R7: a receive request is one cycle long and comes with the word finished
  p_rxreq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rxr_q |-> (!busy_q && rx_full_q) ##1 !rxr_q);

  // R8: the overrun flag holds until it is cleared
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr) |=> ovr_q);

endmodule

// File: rtl/ssi_port.sv
module ssi_port
  import ssi_pkg::*;
#(
  parameter int unsigned MAX_LEN  = SSI_MAX_LEN,
  parameter int unsigned MIN_LEN  = SSI_MIN_LEN,
  parameter int unsigned RELOAD_W = 8,
  parameter int unsigned LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_ext_clk,
  input  logic                cfg_clk_pol,
  input  logic                cfg_msb_first,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [1:0]          cfg_presc,
  input  logic [RELOAD_W-1:0] cfg_reload,
  input  logic [MAX_LEN-1:0]  tx_data,
  input  logic                tx_load,
  input  logic                rx_read,
  input  logic                ovr_clr,
  input  logic                sclk_in,
  input  logic                sdi,
  output logic                sclk_out,
  output logic                sdo,
  output logic [MAX_LEN-1:0]  rx_data,
  output logic                tx_dreq,
  output logic                rx_dreq,
  output logic                rx_ovr
);

  logic [LEN_W-1:0] len_eff;
  logic             idle_lvl;
  logic             busy;
  logic             gen_run;
  logic             int_sclk, int_tgl;
  logic             launch_ev, capture_ev;

  always_comb begin
    if (cfg_len < LEN_W'(MIN_LEN))      len_eff = LEN_W'(MIN_LEN);
    else if (cfg_len > LEN_W'(MAX_LEN)) len_eff = LEN_W'(MAX_LEN);
    else                                len_eff = cfg_len;
  end

  assign idle_lvl = ~cfg_clk_pol;
  assign gen_run  = busy & ~cfg_ext_clk;
  assign sclk_out = int_sclk;

  ssi_baud_gen #(
    .RELOAD_W (RELOAD_W)
  ) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (gen_run),
    .idle_lvl  (idle_lvl),
    .presc_sel (cfg_presc),
    .reload    (cfg_reload),
    .sclk      (int_sclk),
    .tgl       (int_tgl)
  );

  ssi_edge_sel u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .use_ext    (cfg_ext_clk),
    .idle_lvl   (idle_lvl),
    .sclk_ext   (sclk_in),
    .int_sclk   (int_sclk),
    .int_tgl    (int_tgl),
    .launch_ev  (launch_ev),
    .capture_ev (capture_ev)
  );

  ssi_shift_engine #(
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .len_eff    (len_eff),
    .msb_first  (cfg_msb_first),
    .tx_data    (tx_data),
    .tx_load    (tx_load),
    .rx_read    (rx_read),
    .ovr_clr    (ovr_clr),
    .launch_ev  (launch_ev),
    .capture_ev (capture_ev),
    .sdi        (sdi),
    .busy       (busy),
    .sdo        (sdo),
    .rx_data    (rx_data),
    .tx_dreq    (tx_dreq),
    .rx_dreq    (rx_dreq),
    .rx_ovr     (rx_ovr)
  );

  // R1: the clamped length always lies inside the legal window
  p_len_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (len_eff >= LEN_W'(MIN_LEN)) && (len_eff <= LEN_W'(MAX_LEN)));

  // R5: no edge event is derived while idle from the internal generator
  p_no_int_edge_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_ext_clk && $past(!busy)) |-> !(launch_ev || capture_ev));

endmodule

// File: tb/test_ssi_port.sv
`timescale 1ns/1ps
module test_ssi_port;

  logic        clk;
  logic        rst_n;
  logic        cfg_ext_clk, cfg_clk_pol, cfg_msb_first;
  logic [4:0]  cfg_len;
  logic [1:0]  cfg_presc;
  logic [7:0]  cfg_reload;
  logic [15:0] tx_data;
  logic        tx_load, rx_read, ovr_clr;
  logic        sclk_in, sdi_drv, loop_en, sdi;
  logic        sclk_out, sdo;
  logic [15:0] rx_data;
  logic        tx_dreq, rx_dreq, rx_ovr;

  int n_chk;
  int n_fail;
  int n_txr;
  int n_rxr;
  bit finished;

  assign sdi = loop_en ? sdo : sdi_drv;

  ssi_port i_ssi_port (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_ext_clk   (cfg_ext_clk),
    .cfg_clk_pol   (cfg_clk_pol),
    .cfg_msb_first (cfg_msb_first),
    .cfg_len       (cfg_len),
    .cfg_presc     (cfg_presc),
    .cfg_reload    (cfg_reload),
    .tx_data       (tx_data),
    .tx_load       (tx_load),
    .rx_read       (rx_read),
    .ovr_clr       (ovr_clr),
    .sclk_in       (sclk_in),
    .sdi           (sdi),
    .sclk_out      (sclk_out),
    .sdo           (sdo),
    .rx_data       (rx_data),
    .tx_dreq       (tx_dreq),
    .rx_dreq       (rx_dreq),
    .rx_ovr        (rx_ovr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (tx_dreq) n_txr <= n_txr + 1;
    if (rx_dreq) n_rxr <= n_rxr + 1;
  end

  function automatic int eff_len(input int l);
    if (l < 8)  return 8;
    if (l > 16) return 16;
    return l;
  endfunction

  function automatic logic [15:0] lowbits(input logic [15:0] w, input int l);
    logic [15:0] m;
    m = 16'((32'd1 << l) - 1);
    return w & m;
  endfunction

  function automatic int bit_at(input int i, input int l, input bit msb);
    return msb ? (l - 1 - i) : i;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic load_word(input logic [15:0] w);
    @(negedge clk);
    tx_data = w;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic take_word();
    @(negedge clk);
    rx_read = 1'b1;
    @(negedge clk);
    rx_read = 1'b0;
  endtask

  task automatic wait_rx(input int target);
    int guard;
    guard = 0;
    while (n_rxr < target && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check(n_rxr >= target, "R7 receive request arrives", n_rxr, target);
  endtask

  // internal clock with sdo looped back to sdi
  task automatic int_word(input logic [15:0] w, input int l, input bit msb,
                          input bit pol, input logic [1:0] ps, input logic [7:0] rl);
    int tx0;
    int rx0;
    @(negedge clk);
    cfg_ext_clk = 1'b0; loop_en = 1'b1;
    cfg_len = 5'(l); cfg_msb_first = msb; cfg_clk_pol = pol;
    cfg_presc = ps; cfg_reload = rl;
    repeat (2) @(negedge clk);
    tx0 = n_txr; rx0 = n_rxr;
    load_word(w);
    wait_rx(rx0 + 1);
    check(rx_data == lowbits(w, eff_len(l)), "R1 R2 echoed word", rx_data,
          lowbits(w, eff_len(l)));
    check(n_txr == tx0 + 1, "R6 one transmit request per word", n_txr, tx0 + 1);
    check(rx_ovr == 1'b0, "R8 no overrun when read in time", rx_ovr, 0);
    repeat (3) @(negedge clk);
    check(sclk_out == ~pol, "R3 clock rests at idle level", sclk_out, ~pol);
    take_word();
  endtask

  // measure the interval between two sclk_out toggles
  task automatic period_chk(input logic [1:0] ps, input logic [7:0] rl, input int exp);
    int t;
    int t0;
    int rx0;
    logic prev;
    @(negedge clk);
    cfg_ext_clk = 1'b0; loop_en = 1'b1; cfg_len = 5'd8;
    cfg_msb_first = 1'b0; cfg_clk_pol = 1'b0; cfg_presc = ps; cfg_reload = rl;
    repeat (2) @(negedge clk);
    rx0 = n_rxr;
    load_word(16'h00a5);
    prev = sclk_out;
    t = 0;
    while (sclk_out == prev && t < 5000) begin @(negedge clk); t++; end
    prev = sclk_out;
    t0 = t;
    while (sclk_out == prev && t < 5000) begin @(negedge clk); t++; end
    check((t - t0) == exp, "R4 toggle interval", t - t0, exp);
    wait_rx(rx0 + 1);
    check(rx_data == 16'h00a5, "R4 word intact at this rate", rx_data, 16'h00a5);
    take_word();
  endtask

  // bench drives the external clock and checks every bit on sdo
  task automatic ext_word(input logic [15:0] w, input logic [15:0] rw, input int l,
                          input bit msb, input bit pol);
    int rx0;
    int bad;
    int first_bad_i;
    logic [15:0] sent;
    @(negedge clk);
    cfg_ext_clk = 1'b1; loop_en = 1'b0; sclk_in = ~pol;
    cfg_len = 5'(l); cfg_msb_first = msb; cfg_clk_pol = pol;
    repeat (6) @(negedge clk);
    rx0 = n_rxr;
    load_word(w);
    repeat (4) @(negedge clk);
    bad = 0;
    first_bad_i = -1;
    sent = '0;
    for (int i = 0; i < l; i++) begin
      sclk_in = pol;
      repeat (8) @(negedge clk);
      sent[bit_at(i, l, msb)] = sdo;
      if (sdo !== w[bit_at(i, l, msb)]) begin
        bad++;
        if (first_bad_i < 0) first_bad_i = i;
      end
      sdi_drv = rw[bit_at(i, l, msb)];
      repeat (8) @(negedge clk);
      sclk_in = ~pol;
      repeat (8) @(negedge clk);
    end
    check(bad == 0, "R2 R3 R5 transmitted bit order", sent, lowbits(w, l));
    check(n_rxr == rx0 + 1, "R5 R7 one word per external frame", n_rxr, rx0 + 1);
    check(rx_data == lowbits(rw, l), "R2 R5 received word", rx_data, lowbits(rw, l));
    take_word();
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0;
    cfg_ext_clk = 1'b0; cfg_clk_pol = 1'b0; cfg_msb_first = 1'b0;
    cfg_len = 5'd8; cfg_presc = 2'd0; cfg_reload = 8'd1;
    tx_data = '0; tx_load = 1'b0; rx_read = 1'b0; ovr_clr = 1'b0;
    sclk_in = 1'b1; sdi_drv = 1'b0; loop_en = 1'b1;
    n_chk = 0; n_fail = 0; n_txr = 0; n_rxr = 0; finished = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check(sclk_out == 1'b1, "R4 reset clock idle", sclk_out, 1);
    check(tx_dreq == 1'b0 && rx_dreq == 1'b0, "R6 R7 no requests after reset",
          {tx_dreq, rx_dreq}, 0);
    check(rx_ovr == 1'b0 && rx_data == 16'h0, "R8 reset receive state",
          {rx_ovr, rx_data}, 0);

    // directed corners: shortest, longest, clamped lengths
    int_word(16'hffff, 16, 1'b1, 1'b0, 2'd0, 8'd1);
    int_word(16'h005a, 8, 1'b0, 1'b1, 2'd0, 8'd2);
    int_word(16'hbeef, 20, 1'b0, 1'b0, 2'd0, 8'd1);   // R1 clamp to 16
    int_word(16'hc3a5, 3, 1'b1, 1'b1, 2'd0, 8'd1);    // R1 clamp to 8

    // random words
    for (int k = 0; k < 10; k++) begin
      int_word(16'($urandom), 8 + int'($urandom % 9), 1'($urandom),
               1'($urandom), 2'd0, 8'(1 + $urandom % 3));
    end

    // R4 divider intervals
    period_chk(2'd0, 8'd1, 2);
    period_chk(2'd1, 8'd3, 32);
    period_chk(2'd2, 8'd0, 32);
    period_chk(2'd3, 8'd0, 256);

    // R5 external clock, both orders and polarities
    ext_word(16'h1234, 16'h00c7, 8, 1'b0, 1'b0);
    ext_word(16'hace1, 16'h5a3c, 16, 1'b1, 1'b1);
    ext_word(16'h0b6d, 16'h0472, 12, 1'b1, 1'b0);
    ext_word(16'($urandom), 16'($urandom), 11, 1'b0, 1'b1);

    // R5 edges with nothing in flight are ignored
    begin
      int rx0;
      logic s0;
      @(negedge clk);
      cfg_ext_clk = 1'b1; cfg_clk_pol = 1'b0;
      rx0 = n_rxr; s0 = sdo;
      for (int i = 0; i < 20; i++) begin
        sclk_in = ~sclk_in;
        repeat (8) @(negedge clk);
      end
      sclk_in = 1'b1;
      repeat (8) @(negedge clk);
      check(n_rxr == rx0, "R5 idle edges make no word", n_rxr, rx0);
      check(sdo == s0, "R5 idle edges leave sdo", sdo, s0);
    end

    // R8 overrun with back-to-back words and no read
    begin
      int rx0;
      int tx0;
      int g;
      @(negedge clk);
      cfg_ext_clk = 1'b0; loop_en = 1'b1; cfg_len = 5'd9;
      cfg_msb_first = 1'b0; cfg_clk_pol = 1'b0; cfg_presc = 2'd0; cfg_reload = 8'd1;
      repeat (2) @(negedge clk);
      rx0 = n_rxr; tx0 = n_txr;
      load_word(16'h0155);
      g = 0;
      while (n_txr == tx0 && g < 100) begin @(negedge clk); g++; end
      load_word(16'h00aa);
      wait_rx(rx0 + 1);
      check(rx_ovr == 1'b0, "R8 first unread word no overrun", rx_ovr, 0);
      wait_rx(rx0 + 2);
      check(n_txr == tx0 + 2, "R6 held word follows at once", n_txr, tx0 + 2);
      check(rx_ovr == 1'b1, "R8 overrun set", rx_ovr, 1);
      check(rx_data == 16'h00aa, "R8 newest word kept", rx_data, 16'h00aa);
      repeat (5) @(negedge clk);
      check(rx_ovr == 1'b1, "R8 overrun sticky", rx_ovr, 1);
      @(negedge clk); ovr_clr = 1'b1;
      @(negedge clk); ovr_clr = 1'b0;
      @(negedge clk);
      check(rx_ovr == 1'b0, "R8 overrun cleared", rx_ovr, 0);
      take_word();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule